// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Transfer Engine

This block copies words between a peripheral data register and memory, or from one memory region to another, while the processor keeps running. Software fills four configuration words: source address, destination address, unit count and a control word. The control word selects the direction and the bus-sharing policy, enables address stepping for each side, selects whether the block reloads and repeats, and starts the run. Each unit is a read of the source word followed by a write of that word to the destination, issued on a simple master port. The port completes every access in the same cycle and can flag an error.

Before any access the engine must hold ownership of the bus, which it requests from an arbiter and keeps while the grant stays high. Peripheral directions are paced by a level request from the peripheral. Each finished unit is answered with a one-cycle acknowledge. Three sharing policies trade throughput against processor latency. Burst keeps the bus for the whole block. Cycle stealing takes one unit per grant. The idle-cycle policy also takes one unit per grant, and it only touches the bus in cycles where the processor is not using it. Completion and error are reported as one-cycle interrupt pulses.

Top module: `dma_engine`

## Requirements
- R1: Configuration word 0 is the source address, 1 the destination address, 2 the unit count, and 3 the control word. Control bits: [1:0] direction (0 memory-to-memory, 1 peripheral-to-memory, 2 memory-to-peripheral), [3:2] policy (0 burst, 1 cycle stealing, 2 idle-cycle only), bit 4 source step, bit 5 destination step, bit 6 repeat, bit 7 start. Reading word 3 returns bits [6:0] as written and bit 8 set while a run is active. Writes made while a run is active are ignored.
- R2: Each unit reads the current source address and then writes the value it read to the current destination address, in the following cycle in which access is allowed.
- R3: In the two peripheral directions a unit starts only while the peripheral request is high. Each completed unit raises the peripheral acknowledge for exactly one cycle, the cycle after its write. Memory-to-memory runs never acknowledge.
- R4: No access is issued unless the engine drives its bus request and the grant is high.
- R5: After each write, every address whose step bit is set increases by one and the rest stay fixed, and the remaining count decreases by one. Reads of words 0 to 2 return the live values.
- R6: In burst policy the bus request stays high from the first grant until the final write of the block. The request therefore rises exactly once per block.
- R7: In cycle-stealing policy the bus request falls in the cycle after each write. The request rises once per unit.
- R8: In idle-cycle policy no access is issued in a cycle where the processor-busy input is high. Ownership is taken once per unit.
- R9: When the count reaches zero, the completion interrupt pulses for one cycle in the cycle after the final write, the bus request is low, and the active bit clears.
- R10: With repeat set, reaching zero reloads the original addresses and count, pulses the completion interrupt, and starts the next pass. No write lands outside the original destination window.
- R11: An error flagged on any access ends the run. The error interrupt pulses once, there is no completion pulse, the bus is released, the faulting unit is not counted, and its addresses do not advance.
- R12: Starting with a count of zero pulses the error interrupt and never requests the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select, for both write and read |
| cfg_wdata | input | AW | Configuration write data |
| cfg_rdata | output | AW | Read value of the selected configuration word |
| periph_req | input | 1 | Peripheral has a unit ready or room for one |
| periph_ack | output | 1 | One-cycle pulse after each peripheral unit |
| bus_req | output | 1 | Bus ownership request to the arbiter |
| bus_gnt | input | 1 | Bus ownership grant |
| cpu_busy | input | 1 | Processor is using the bus this cycle |
| m_en | output | 1 | Master access valid this cycle |
| m_we | output | 1 | Master access is a write |
| m_addr | output | AW | Master word address |
| m_wdata | output | DW | Master write data |
| m_rdata | input | DW | Master read data, valid in the access cycle |
| m_err | input | 1 | Access error, valid in the access cycle |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
The assertions assume an arbiter that keeps the grant high for as long as the request is held, and a memory port that answers reads and flags errors within the access cycle. The bench arbiter registers the request into the grant, so a grant always follows its request by one cycle. The bench memory is combinational on the address, and it flags an error on exactly one known address. The processor-busy input and the peripheral request follow fixed cycle patterns. With these patterns the engine meets both stalls and waits in every policy and direction.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_REQ,
        ST_RD,
        ST_WR
    } state_e;

    typedef enum logic [1:0] {
        DIR_M2M = 2'd0,
        DIR_P2M = 2'd1,
        DIR_M2P = 2'd2,
        DIR_RSV = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        MODE_BURST = 2'd0,
        MODE_STEAL = 2'd1,
        MODE_TRANS = 2'd2
    } mode_e;

    localparam logic [1:0] REG_SRC = 2'd0;
    localparam logic [1:0] REG_DST = 2'd1;
    localparam logic [1:0] REG_CNT = 2'd2;
    localparam logic [1:0] REG_CTL = 2'd3;

    localparam int CTL_SINC = 4;
    localparam int CTL_DINC = 5;
    localparam int CTL_CIRC = 6;
    localparam int CTL_GO   = 7;
    localparam int CTL_BUSY = 8;

    function automatic mode_e decode_mode(input logic [1:0] f);
        case (f)
            2'd1:    return MODE_STEAL;
            2'd2:    return MODE_TRANS;
            default: return MODE_BURST;
        endcase
    endfunction

    function automatic logic dir_is_periph(input dir_e d);
        return (d == DIR_P2M) || (d == DIR_M2P);
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic          inc,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        nxt = inc ? cur + ONE : cur;
    end
endmodule

// File: rtl/dma_bus_gate.sv
module dma_bus_gate
    import dma_pkg::*;
(
    input  mode_e mode,
    input  logic  gnt,
    input  logic  cpu_busy,
    output logic  go
);
    always_comb begin
        go = gnt && !((mode == MODE_TRANS) && cpu_busy);
    end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic          cpu_busy,
    output logic          m_en,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_err,
    output logic          irq_done,
    output logic          irq_err
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam int NSIDE = 2;

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] cnt;
        logic [AW-1:0] src0;
        logic [AW-1:0] dst0;
        logic [AW-1:0] cnt0;
        dir_e          dir;
        mode_e         mode;
        logic          sinc;
        logic          dinc;
        logic          circ;
        logic          own;
        logic [DW-1:0] dat;
        logic          ack;
        logic          done;
        logic          err;
    } regs_t;

    regs_t d, q;

    logic [AW-1:0] step_cur [NSIDE];
    logic          step_inc [NSIDE];
    logic [AW-1:0] step_nxt [NSIDE];

    assign step_cur[0] = q.src;
    assign step_cur[1] = q.dst;
    assign step_inc[0] = q.sinc;
    assign step_inc[1] = q.dinc;

    for (genvar g = 0; g < NSIDE; g++) begin : g_step
        dma_addr_step #(.AW(AW)) u_step (
            .cur (step_cur[g]),
            .inc (step_inc[g]),
            .nxt (step_nxt[g])
        );
    end

    logic go;
    dma_bus_gate u_gate (
        .mode     (q.mode),
        .gnt      (bus_gnt),
        .cpu_busy (cpu_busy),
        .go       (go)
    );

    logic periph;
    logic busy;
    logic access;
    logic [AW-1:0] ctl_view;

    always_comb begin
        periph   = dir_is_periph(q.dir);
        busy     = (q.st != ST_IDLE);
        access   = ((q.st == ST_RD) || (q.st == ST_WR)) && go;

        ctl_view = '0;
        ctl_view[1:0]    = q.dir;
        ctl_view[3:2]    = q.mode;
        ctl_view[CTL_SINC] = q.sinc;
        ctl_view[CTL_DINC] = q.dinc;
        ctl_view[CTL_CIRC] = q.circ;
        ctl_view[CTL_BUSY] = busy;

        case (cfg_addr)
            REG_SRC: cfg_rdata = q.src;
            REG_DST: cfg_rdata = q.dst;
            REG_CNT: cfg_rdata = q.cnt;
            default: cfg_rdata = ctl_view;
        endcase

        bus_req    = (q.st == ST_REQ) || (q.st == ST_RD) || (q.st == ST_WR)
                   || ((q.st == ST_PEND) && q.own);
        m_en       = access;
        m_we       = (q.st == ST_WR);
        m_addr     = (q.st == ST_WR) ? q.dst : q.src;
        m_wdata    = q.dat;
        periph_ack = q.ack;
        irq_done   = q.done;
        irq_err    = q.err;
    end

    always_comb begin
        d      = q;
        d.ack  = 1'b0;
        d.done = 1'b0;
        d.err  = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (cfg_we) begin
                    case (cfg_addr)
                        REG_SRC: begin
                            d.src  = cfg_wdata;
                            d.src0 = cfg_wdata;
                        end
                        REG_DST: begin
                            d.dst  = cfg_wdata;
                            d.dst0 = cfg_wdata;
                        end
                        REG_CNT: begin
                            d.cnt  = cfg_wdata;
                            d.cnt0 = cfg_wdata;
                        end
                        default: begin
                            d.dir  = dir_e'(cfg_wdata[1:0]);
                            d.mode = decode_mode(cfg_wdata[3:2]);
                            d.sinc = cfg_wdata[CTL_SINC];
                            d.dinc = cfg_wdata[CTL_DINC];
                            d.circ = cfg_wdata[CTL_CIRC];
                            if (cfg_wdata[CTL_GO]) begin
                                d.src = q.src0;
                                d.dst = q.dst0;
                                d.cnt = q.cnt0;
                                d.own = 1'b0;
                                if (q.cnt0 == '0) begin
                                    d.err = 1'b1;
                                end else begin
                                    d.st = ST_PEND;
                                end
                            end
                        end
                    endcase
                end
            end

            ST_PEND: begin
                if (!periph || periph_req) begin
                    d.st = q.own ? ST_RD : ST_REQ;
                end
            end

            ST_REQ: begin
                if (bus_gnt) begin
                    d.st  = ST_RD;
                    d.own = 1'b1;
                end
            end

            ST_RD: begin
                if (go) begin
                    if (m_err) begin
                        d.err = 1'b1;
                        d.own = 1'b0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.dat = m_rdata;
                        d.st  = ST_WR;
                    end
                end
            end

            ST_WR: begin
                if (go) begin
                    if (m_err) begin
                        d.err = 1'b1;
                        d.own = 1'b0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.src = step_nxt[0];
                        d.dst = step_nxt[1];
                        d.cnt = q.cnt - ONE;
                        d.ack = periph;
                        if (q.cnt == ONE) begin
                            d.done = 1'b1;
                            d.own  = 1'b0;
                            if (q.circ) begin
                                d.src = q.src0;
                                d.dst = q.dst0;
                                d.cnt = q.cnt0;
                                d.st  = ST_PEND;
                            end else begin
                                d.st  = ST_IDLE;
                            end
                        end else begin
                            d.st  = ST_PEND;
                            d.own = (q.mode == MODE_BURST);
                        end
                    end
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R4: every access happens under a held request and a live grant
    a_r4_access_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        m_en |-> (bus_gnt && bus_req));

    // R8: idle-cycle policy never collides with the processor
    a_r8_idle_cycles_only: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && (q.mode == MODE_TRANS)) |-> !cpu_busy);

    // R7: stealing gives the bus back right after each write
    a_r7_release_after_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && m_we && !m_err && (q.mode == MODE_STEAL)) |=> !bus_req);

    // R6: burst keeps the bus between units of one block
    a_r6_burst_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && m_we && !m_err && (q.mode == MODE_BURST) && (q.cnt > ONE)) |=> bus_req);

    // R5: the count steps down by one per completed unit
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && m_we && !m_err && (q.cnt > ONE)) |=> (q.cnt == $past(q.cnt) - ONE));

    // R5: an active run never holds a zero count
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> (q.cnt != '0));

    // R3: acknowledge only follows a finished write
    a_r3_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> $past(m_en && m_we && !m_err));

    // R11: an error releases the bus and reports it
    a_r11_error_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && m_err) |=> (!bus_req && irq_err && !irq_done));

    // R9: completion follows the final write
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> ($past(m_en && m_we) && ($past(q.cnt) == ONE)));

endmodule

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          periph_req;
    logic          periph_ack;
    logic          bus_req;
    logic          bus_gnt;
    logic          cpu_busy;
    logic          m_en, m_we;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata, m_rdata;
    logic          m_err;
    logic          irq_done, irq_err;

    dma_engine #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .periph_req(periph_req), .periph_ack(periph_ack),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .cpu_busy(cpu_busy),
        .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_err(m_err),
        .irq_done(irq_done), .irq_err(irq_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic busy_pat = 1'b0;
    logic preq_pat = 1'b0;
    logic trans_run = 1'b0;
    logic mem_init = 1'b1;
    logic clr_mon = 1'b1;

    assign cpu_busy   = busy_pat && (cyc % 3 == 1);
    assign periph_req = preq_pat && (cyc % 4 != 0);

    function automatic logic [DW-1:0] init_word(input int i);
        return DW'(32'h1000 + i * 37);
    endfunction

    logic [DW-1:0] mem [64];
    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
        end else if (m_en && m_we && !m_err) begin
            mem[m_addr[5:0]] <= m_wdata;
        end
    end
    assign m_rdata = mem[m_addr[5:0]];
    assign m_err   = m_en && (m_addr[5:0] == 6'd63);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_gnt <= 1'b0;
        else        bus_gnt <= bus_req;
    end

    int n_done, n_err, n_ack, n_rise, n_nogrant, n_transviol, n_oob;
    logic req_prev;
    always @(negedge clk) begin
        if (clr_mon) begin
            n_done = 0; n_err = 0; n_ack = 0; n_rise = 0;
            n_nogrant = 0; n_transviol = 0; n_oob = 0; req_prev = 1'b0;
        end else begin
            if (irq_done) n_done++;
            if (irq_err) n_err++;
            if (periph_ack) n_ack++;
            if (bus_req && !req_prev) n_rise++;
            req_prev = bus_req;
            if (m_en && !bus_gnt) n_nogrant++;
            if (m_en && cpu_busy && trans_run) n_transviol++;
            if (m_en && m_we && !m_err && m_addr >= 35 && m_addr < 48) n_oob++;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic wr(input logic [1:0] a, input int v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = AW'(v);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        cfg_addr = a; #1;
        v = int'(cfg_rdata);
    endtask

    task automatic wait_idle();
        int v;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            rd(2'd3, v);
            if (((v >> 8) & 1) == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic prep();
        @(posedge clk); #1; mem_init = 1'b1; clr_mon = 1'b1;
        @(posedge clk); #1; mem_init = 1'b0;
        @(negedge clk); #1; clr_mon = 1'b0;
    endtask

    task automatic start(input int s, input int dd, input int n, input int ctl);
        wr(2'd0, s);
        wr(2'd1, dd);
        wr(2'd2, n);
        wr(2'd3, ctl);
    endtask

    task automatic sweep_one(input int dir, input int mode, input int n);
        int s, dd, si, di, ctl, v, bad;
        s  = (dir == 1) ? 48 : 16;
        dd = (dir == 0) ? 32 : ((dir == 1) ? 8 : 49);
        si = (dir == 1) ? 0 : 1;
        di = (dir == 2) ? 0 : 1;
        ctl = dir | (mode << 2) | (si << 4) | (di << 5) | (1 << 7);
        busy_pat = 1'b1;
        preq_pat = (dir != 0);
        trans_run = (mode == 2);
        prep();
        start(s, dd, n, ctl);
        wait_idle();
        bad = 0;
        if (dir == 0) begin
            for (int i = 0; i < n; i++) if (mem[32 + i] != init_word(16 + i)) bad++;
        end else if (dir == 1) begin
            for (int i = 0; i < n; i++) if (mem[8 + i] != init_word(48)) bad++;
        end else begin
            if (mem[49] != init_word(16 + n - 1)) bad++;
        end
        chk((dir == 0) ? "R2 data copy" : "R3 peripheral data", bad, 0);
        chk("R3 acknowledge count", n_ack, (dir != 0) ? n : 0);
        chk("R9 completion pulses", n_done, 1);
        chk("R9 no error", n_err, 0);
        chk("R9 bus released", int'(bus_req), 0);
        chk("R4 access without grant", n_nogrant, 0);
        if (mode == 0) chk("R6 burst request rises", n_rise, 1);
        else if (mode == 1) chk("R7 stealing request rises", n_rise, n);
        else begin
            chk("R8 request rises", n_rise, n);
            chk("R8 access in busy cycle", n_transviol, 0);
        end
        rd(2'd2, v); chk("R5 remaining count", v, 0);
        rd(2'd0, v); chk("R5 source final", v, s + si * n);
        rd(2'd1, v); chk("R5 destination final", v, dd + di * n);
        rd(2'd3, v); chk("R1 control readback", v, ctl & 8'h7f);
    endtask

    initial begin
        int v;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1; mem_init = 1'b0; clr_mon = 1'b0;
        @(negedge clk);

        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset readback", v, 0);
        end
        chk("R9 reset bus request", int'(bus_req), 0);
        chk("R9 reset interrupts", int'(irq_done) + int'(irq_err), 0);

        // R2 R3 R5 R6 R7 R8 R9: every direction, policy and a few lengths
        for (int dir = 0; dir < 3; dir++)
            for (int mode = 0; mode < 3; mode++)
                for (int k = 0; k < 4; k++)
                    sweep_one(dir, mode, (k == 3) ? 5 : k + 1);

        // R12: zero length start
        busy_pat = 1'b0; preq_pat = 1'b0; trans_run = 1'b0;
        prep();
        start(16, 32, 0, 8'h80 | (1 << 2));
        repeat (6) @(negedge clk);
        chk("R12 error pulse", n_err, 1);
        chk("R12 no bus request", n_rise, 0);
        rd(2'd3, v); chk("R12 stays idle", (v >> 8) & 1, 0);

        // R1: writes during a run are ignored
        prep();
        start(16, 32, 5, 8'h80 | (1 << 2) | (3 << 4));
        repeat (3) @(posedge clk);
        wr(2'd0, 60);
        wr(2'd2, 1);
        wait_idle();
        rd(2'd0, v); chk("R1 source write ignored", v, 21);
        chk("R1 run length unchanged", n_done, 1);
        chk("R1 last word copied", int'(mem[36] == init_word(20)), 1);

        // R11: error on the fourth read of a burst
        prep();
        start(60, 32, 5, 8'h80 | (3 << 4));
        wait_idle();
        chk("R11 error pulse", n_err, 1);
        chk("R11 no completion", n_done, 0);
        rd(2'd2, v); chk("R11 remaining count", v, 2);
        rd(2'd0, v); chk("R11 faulting source kept", v, 63);
        chk("R11 bus released", int'(bus_req), 0);
        chk("R11 earlier units stored", int'(mem[34] == init_word(62)), 1);

        // R10: repeat mode wraps and keeps running
        prep();
        start(16, 32, 3, 8'h80 | (1 << 2) | (3 << 4) | (1 << 6));
        for (int k = 0; k < 2000; k++) begin
            @(posedge clk);
            if (n_done >= 2) break;
        end
        @(negedge clk);
        chk("R10 two completions", (n_done >= 2) ? 1 : 0, 1);
        rd(2'd3, v); chk("R10 still active", (v >> 8) & 1, 1);
        chk("R10 writes inside window", n_oob, 0);
        chk("R10 no error", n_err, 0);
        v = 0;
        for (int i = 0; i < 3; i++) if (mem[32 + i] != init_word(16 + i)) v++;
        chk("R10 window data", v, 0);
        #1; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        rd(2'd3, v); chk("R1 reset stops run", (v >> 8) & 1, 0);

        summary();
    end
endmodule